// File: doc/BRIEF.md
# Double-Buffered Memory Read Unit

This unit feeds a fixed-latency dataflow datapath from system memory, whose access time is not fixed. It owns two equal word buffers. During a run, a fetch engine reads a block of words from memory into one buffer over a valid/ready request bus with in-order responses. At the same time, the other buffer plays its contents to the datapath at one word per clock, without pausing. Each accepted run start swaps the roles of the two buffers. A block fetched in one run therefore reaches the datapath in the following run.

The unit keeps no configuration of its own. The base byte address and the word count come in on configuration inputs, which the surrounding logic holds steady from the start of a run until done returns. A run begins with a one-cycle pulse on `run`. `running` stays high until both halves of the run have finished, and `done` is its complement.

Top module: `dbuf_read_unit`

## Requirements
- R1: While reset is asserted and after its release, running is 0, done is 1, out_valid is 0 and mem_req_valid is 0.
- R2: A run pulse is accepted only while done is 1. A pulse that arrives while running is 1 has no effect: it neither restarts the counters nor swaps the buffers.
- R3: During a run with effective length L, the unit issues exactly L read requests at byte addresses base, base+4, base+8, and so on, in that order. It issues no further requests.
- R4: The words returned by memory in run N, in response order, are the words emitted on out_data in run N+1, from index 0 upward. Buffer entries that are not refilled keep their older contents.
- R5: If the start is accepted at clock edge s, the stream words are present after edges s+1 through s+L, one per cycle with no gap, whatever the memory latency.
- R6: In the first run after reset, out_valid stays 0 for the whole run.
- R7: done drops after the start edge. It rises one edge after the later of two events: the edge that took the last memory response, and edge s+L.
- R8: A configured length larger than DEPTH is treated as DEPTH, both for requests and for emitted words.
- R9: A run with length 0 issues no requests, emits no words, and completes with done high after edge s+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Run start pulse |
| cfg_base | input | ADDR_W | Byte address of the first word to fetch |
| cfg_len | input | CFG_LEN_W | Word count for the run, clamped to DEPTH |
| running | output | 1 | Run in progress |
| done | output | 1 | Idle; previous run complete |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | ADDR_W | Read request byte address |
| mem_rsp_valid | input | 1 | Read data valid (in request order) |
| mem_rsp_data | input | DATA_W | Read data |
| out_valid | output | 1 | Stream word valid for the datapath |
| out_data | output | DATA_W | Stream word |

## Verification
The bench records the number of the edge that accepts each start. It then expects the stream words after edges s+1 to s+L, and it measures the first and last beats against those two edge numbers. It also records the edge that takes each memory response. The first sample with done high must fall at one edge past the later of the last response and s+L, which also covers the zero-length run at s+1. Requests are compared against the expected address the moment the handshake is set up. All outputs are sampled on the falling edge, after every register on the path has settled.

// File: rtl/dbr_pkg.sv
package dbr_pkg;
   typedef enum logic {BANK_A = 1'b0, BANK_B = 1'b1} bank_e;
   localparam int WORD_SHIFT = 2;  // 4 bytes per word
endpackage

// File: rtl/dbr_banks.sv
module dbr_banks
   import dbr_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 16,
   parameter int IDX_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  bank_e             wr_bank,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   input  bank_e             rd_bank,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_data
);
   logic [DATA_W-1:0] bank_word [2];

   for (genvar b = 0; b < 2; b++) begin : g_bank
      logic [DATA_W-1:0] mem [DEPTH];
      always_ff @(posedge clk) begin
         if (wr_en && (int'(wr_bank) == b)) mem[wr_idx] <= wr_data;
      end
      assign bank_word[b] = mem[rd_idx];
   end

   always_ff @(posedge clk) begin
      if (rd_en) rd_data <= bank_word[rd_bank];
   end

   // R4: the fill side and the stream side never share a buffer
   a_r4_bank_split: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && rd_en) |-> (wr_bank != rd_bank));
endmodule

// File: rtl/dbr_fetch.sv
module dbr_fetch
   import dbr_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int IDX_W  = 4,
   parameter int CNT_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              active,
   input  logic [CNT_W-1:0]  len,
   input  logic [ADDR_W-1:0] base,
   output logic              req_valid,
   input  logic              req_ready,
   output logic [ADDR_W-1:0] req_addr,
   input  logic              rsp_valid,
   input  logic [DATA_W-1:0] rsp_data,
   output logic              wr_en,
   output logic [IDX_W-1:0]  wr_idx,
   output logic [DATA_W-1:0] wr_data,
   output logic              fill_done
);
   logic [CNT_W-1:0] req_cnt, rsp_cnt;

   assign req_valid = active && (req_cnt < len);
   assign req_addr  = base + (ADDR_W'(req_cnt) << WORD_SHIFT);
   assign wr_en     = active && rsp_valid && (rsp_cnt < len);
   assign wr_idx    = rsp_cnt[IDX_W-1:0];
   assign wr_data   = rsp_data;
   assign fill_done = (rsp_cnt == len);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_cnt <= '0;
         rsp_cnt <= '0;
      end else if (start) begin
         req_cnt <= '0;
         rsp_cnt <= '0;
      end else begin
         if (req_valid && req_ready) req_cnt <= req_cnt + 1'b1;
         if (wr_en)                  rsp_cnt <= rsp_cnt + 1'b1;
      end
   end

   // R3: consecutive requests step by one word
   a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (!req_valid || (req_addr == $past(req_addr) + ADDR_W'(4))));
   // R3: a response is only stored for a request already issued
   a_r3_rsp_after_req: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (rsp_cnt < req_cnt));
endmodule

// File: rtl/dbr_stream.sv
module dbr_stream #(
   parameter int IDX_W = 4,
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             active,
   input  logic             primed,
   input  logic [CNT_W-1:0] len,
   output logic             rd_en,
   output logic [IDX_W-1:0] rd_idx,
   output logic             out_valid,
   output logic             stream_done
);
   logic [CNT_W-1:0] out_cnt;
   logic             beat;

   assign rd_en       = active && (out_cnt < len);
   assign rd_idx      = out_cnt[IDX_W-1:0];
   assign stream_done = (out_cnt == len);
   assign out_valid   = beat && primed;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_cnt <= '0;
         beat    <= 1'b0;
      end else if (start) begin
         out_cnt <= '0;
         beat    <= 1'b0;
      end else begin
         beat <= rd_en;
         if (rd_en) out_cnt <= out_cnt + 1'b1;
      end
   end

   // R5: the stream only stops after the full word count
   a_r5_full_count: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(beat) |-> (out_cnt == len));
endmodule

// File: rtl/dbuf_read_unit.sv
module dbuf_read_unit
   import dbr_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 32,
   parameter int DEPTH     = 16,
   parameter int CFG_LEN_W = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 run,
   input  logic [ADDR_W-1:0]    cfg_base,
   input  logic [CFG_LEN_W-1:0] cfg_len,
   output logic                 running,
   output logic                 done,
   output logic                 mem_req_valid,
   input  logic                 mem_req_ready,
   output logic [ADDR_W-1:0]    mem_req_addr,
   input  logic                 mem_rsp_valid,
   input  logic [DATA_W-1:0]    mem_rsp_data,
   output logic                 out_valid,
   output logic [DATA_W-1:0]    out_data
);
   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = $clog2(DEPTH + 1);

   if (DEPTH < 2) begin : g_bad_depth
      $error("dbuf_read_unit: DEPTH must be at least 2");
   end
   if (ADDR_W < 3) begin : g_bad_addr
      $error("dbuf_read_unit: ADDR_W too small");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("dbuf_read_unit: DATA_W must be positive");
   end

   logic             start, fill_done, stream_done, primed, ran_once;
   bank_e            fill_sel, read_sel;
   logic [CNT_W-1:0] len_eff;
   logic             wr_en, rd_en;
   logic [IDX_W-1:0] wr_idx, rd_idx;
   logic [DATA_W-1:0] wr_data;

   assign len_eff  = (cfg_len > CFG_LEN_W'(DEPTH)) ? CNT_W'(DEPTH) : CNT_W'(cfg_len);
   assign start    = run && !running;
   assign done     = !running;
   assign read_sel = (fill_sel == BANK_A) ? BANK_B : BANK_A;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         running  <= 1'b0;
         fill_sel <= BANK_A;
         primed   <= 1'b0;
         ran_once <= 1'b0;
      end else if (start) begin
         running  <= 1'b1;
         fill_sel <= read_sel;
         primed   <= ran_once;
         ran_once <= 1'b1;
      end else if (running && fill_done && stream_done) begin
         running  <= 1'b0;
      end
   end

   dbr_fetch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_fetch (
      .clk(clk), .rst_n(rst_n), .start(start), .active(running), .len(len_eff),
      .base(cfg_base), .req_valid(mem_req_valid), .req_ready(mem_req_ready),
      .req_addr(mem_req_addr), .rsp_valid(mem_rsp_valid), .rsp_data(mem_rsp_data),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .fill_done(fill_done)
   );

   dbr_stream #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_stream (
      .clk(clk), .rst_n(rst_n), .start(start), .active(running), .primed(primed),
      .len(len_eff), .rd_en(rd_en), .rd_idx(rd_idx), .out_valid(out_valid),
      .stream_done(stream_done)
   );

   dbr_banks #(.DATA_W(DATA_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_banks (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_bank(fill_sel), .wr_idx(wr_idx),
      .wr_data(wr_data), .rd_en(rd_en), .rd_bank(read_sel), .rd_idx(rd_idx),
      .rd_data(out_data)
   );

   // R7: completion needs both the fill and the stream side
   a_r7_done_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(fill_done && stream_done));
   // R2: buffer roles hold for the whole run
   a_r2_roles_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (running && $past(running)) |-> $stable(fill_sel));
endmodule

// File: tb/test_dbuf_read_unit.sv
`timescale 1ns/1ps
module test_dbuf_read_unit;
   localparam int DATA_W = 32, ADDR_W = 32, DEPTH = 16, CFG_LEN_W = 8;

   logic clk = 1'b0, rst_n = 1'b0, run = 1'b0;
   logic [ADDR_W-1:0] cfg_base = '0;
   logic [CFG_LEN_W-1:0] cfg_len = '0;
   logic running, done, mem_req_valid, mem_req_ready = 1'b0, mem_rsp_valid = 1'b0, out_valid;
   logic [ADDR_W-1:0] mem_req_addr;
   logic [DATA_W-1:0] mem_rsp_data = '0, out_data;

   always #2.5 clk = ~clk;

   dbuf_read_unit #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DEPTH(DEPTH), .CFG_LEN_W(CFG_LEN_W)) i_dbuf_read_unit (
      .clk(clk), .rst_n(rst_n), .run(run), .cfg_base(cfg_base), .cfg_len(cfg_len),
      .running(running), .done(done), .mem_req_valid(mem_req_valid),
      .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
      .out_valid(out_valid), .out_data(out_data)
   );

   int n_cmp = 0, n_bad = 0, cyc = 0;
   int mode = 0, beats = 0, first_beat = -1, last_beat = -1, last_rsp = 0, msel = 0;
   bit ran_before = 0;
   logic [7:0] epoch = 8'h00;
   logic [15:0] lfsr = 16'hACE1;
   logic [31:0] exp_words[$], exp_addrs[$], pend[$];
   logic [31:0] mbank [2][DEPTH];

   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic [31:0] mem_val(logic [31:0] a, logic [7:0] e);
      return {e, a[23:0]};
   endfunction

   task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // monitor and memory responder
   always @(negedge clk) begin
      logic gate_req, gate_rsp;
      logic [31:0] a;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (out_valid === 1'b1) begin
         beats++;
         if (first_beat < 0) first_beat = cyc + 0;
         last_beat = cyc;
         if (exp_words.size() == 0) chk(0, "R5 R6 unexpected stream word", out_data, 0);
         else begin
            a = exp_words.pop_front();
            chk(out_data === a, "R4 stream word", out_data, a);
         end
      end
      case (mode)
         0: begin gate_req = 1'b1; gate_rsp = 1'b1; end
         1: begin gate_req = lfsr[0]; gate_rsp = lfsr[1]; end
         default: begin gate_req = lfsr[0] & lfsr[1]; gate_rsp = (cyc % 5) == 0; end
      endcase
      if (pend.size() > 0 && gate_rsp) begin
         mem_rsp_valid = 1'b1;
         mem_rsp_data  = mem_val(pend.pop_front(), epoch);
         last_rsp      = cyc + 1;
      end else begin
         mem_rsp_valid = 1'b0;
         mem_rsp_data  = '0;
      end
      mem_req_ready = gate_req;
      if (mem_req_valid === 1'b1 && mem_req_ready) begin
         pend.push_back(mem_req_addr);
         if (exp_addrs.size() == 0) chk(0, "R3 R8 extra request", mem_req_addr, 0);
         else begin
            a = exp_addrs.pop_front();
            chk(mem_req_addr === a, "R3 request address", mem_req_addr, a);
         end
      end
   end

   task automatic do_run(input logic [31:0] base, input int len, input int md, input bit extra);
      int L, s, due;
      bit pr;
      L = (len > DEPTH) ? DEPTH : len;
      @(negedge clk);
      cfg_base = base;
      cfg_len  = CFG_LEN_W'(len);
      mode     = md;
      epoch    = epoch + 8'h11;
      msel    ^= 1;
      pr = ran_before;
      ran_before = 1;
      if (pr) for (int i = 0; i < L; i++) exp_words.push_back(mbank[msel ^ 1][i]);
      for (int i = 0; i < L; i++) exp_addrs.push_back(base + 32'(4 * i));
      beats = 0; first_beat = -1; last_beat = -1;
      run = 1'b1;
      s = cyc + 1;
      last_rsp = s;
      @(negedge clk);
      run = 1'b0;
      chk(running === 1'b1 && done === 1'b0, "R7 busy after start", {running, done}, 2'b10);
      if (extra) begin
         run = 1'b1;
         @(negedge clk);
         run = 1'b0;
         chk(running === 1'b1, "R2 pulse while running", running, 1);
      end
      while (done !== 1'b1) @(negedge clk);
      due = ((s + L) > last_rsp) ? (s + L + 1) : (last_rsp + 1);
      chk(cyc == due, "R7 R9 done edge", cyc, due);
      chk(exp_addrs.size() == 0, "R3 R8 missing requests", exp_addrs.size(), 0);
      chk(exp_words.size() == 0, "R4 R5 missing stream words", exp_words.size(), 0);
      chk(beats == (pr ? L : 0), "R5 R6 R8 word count", beats, pr ? L : 0);
      if (pr && L > 0) begin
         chk(first_beat == s + 1, "R5 first word edge", first_beat, s + 1);
         chk(last_beat == s + L, "R5 last word edge", last_beat, s + L);
      end
      for (int i = 0; i < L; i++) mbank[msel][i] = mem_val(base + 32'(4 * i), epoch);
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      chk(running === 1'b0 && done === 1'b1, "R1 reset run state", {running, done}, 2'b01);
      chk(out_valid === 1'b0 && mem_req_valid === 1'b0, "R1 reset outputs",
          {out_valid, mem_req_valid}, 2'b00);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(done === 1'b1 && out_valid === 1'b0, "R1 after release", {done, out_valid}, 2'b10);
      do_run(32'h0000_1000, 16, 0, 0);  // R6 first run, no valid words
      do_run(32'h0000_2000, 40, 1, 0);  // R8 clamp to DEPTH
      do_run(32'h0000_3000, 5, 2, 1);   // R2 ignored pulse, slow memory
      do_run(32'h0000_4000, 3, 1, 0);
      do_run(32'h0000_5000, 0, 0, 0);   // R9 empty run
      do_run(32'h0000_6000, 16, 0, 0);  // R4 stale entries retained
      do_run(32'h0000_7000, 2, 2, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(5.0 * 100000);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule